// File: doc/BRIEF.md
# DRAM Automatic Access Sequencer

This block turns a single active-low access strobe into a complete row/column access on a multiplexed DRAM address bus. The system puts a row half, a column half and a two-bit bank field on the inputs, then pulls the strobe low. While the strobe is high the address inputs flow straight through. When the strobe is first seen low, the row half, column half and bank field are captured. The block then:

- drops one of four row strobes, chosen by the bank field;
- holds the row address for a mode-dependent number of clock cycles;
- moves the output bus to the column half;
- waits one column-setup cycle;
- drops the column strobe.

Raising the strobe ends the access on the next clock.

A three-bit mode code selects the behaviour. Code 101 runs the automatic sequence with the long row hold. Code 110 runs it with the short row hold. Code 100 hands the row strobe, the column strobe and the row/column select to three external pins, which the block registers and passes on. Every other code leaves the memory side idle.

The write enable is a plain buffer that does not depend on the sequencer. In the two automatic modes, a hidden-refresh request that arrives during an access is held back. It is granted as a one-cycle flag once the strobe is high again; the refresh itself is done elsewhere.

Top module: `dram_access_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, all row strobes and the column strobe are high (inactive) and the refresh grant is low.
- R2: Mode 101 uses a row hold of 2 cycles and mode 110 uses 1 cycle. The column strobe therefore falls 3 cycles (101) or 2 cycles (110) after the row strobe falls.
- R3: In mode 101 or 110, the clock edge that first samples the strobe low drives the selected row strobe low, with the row address on addr_o.
- R4: The active row strobe is ras_n_o[bank], where bank is the captured 2-bit bank field. At most one row strobe is ever low.
- R5: addr_o changes from the row half to the column half exactly at the end of the row-hold interval.
- R6: The column strobe falls one column-setup cycle after addr_o switches to the column half, and addr_o does not change on the edge where the column strobe falls.
- R7: On the edge that samples the strobe high in an automatic mode, all row strobes and the column strobe go high and addr_o shows the live row input.
- R8: The row, column and bank inputs are transparent while the strobe is high. They are held from the first low-sampled edge, so input changes during an access have no effect on addr_o or on which row strobe is low.
- R9: In mode 100, one cycle after each edge:
  - the selected row strobe equals ext_row_n_i, and the other row strobes are high;
  - cas_n_o equals ext_col_n_i;
  - addr_o shows the column half when ext_sel_col_i is 1 and the row half when it is 0.
- R10: wr_n_o equals wr_n_i with no clock delay in every mode.
- R11: In modes 101 and 110, a refresh request seen while the strobe is low does not raise refresh_ok_o. refresh_ok_o is high for one cycle after the first edge that samples the strobe high. A request seen while the strobe is high is granted on the next edge. In other modes the grant stays low.
- R12: Mode codes other than 100, 101 and 110 keep all row strobes and the column strobe high, whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Mode code (100 external, 101 slow auto, 110 fast auto) |
| strobe_n_i | input | 1 | Access strobe, active low |
| row_addr_i | input | ADDR_W | Row half of the parallel address |
| col_addr_i | input | ADDR_W | Column half of the parallel address |
| bank_i | input | BANK_W | Bank field selecting the row strobe |
| ext_row_n_i | input | 1 | External row strobe for mode 100 |
| ext_col_n_i | input | 1 | External column strobe for mode 100 |
| ext_sel_col_i | input | 1 | External row/column select for mode 100 (1 = column) |
| wr_n_i | input | 1 | System write enable, active low |
| refresh_req_i | input | 1 | Hidden-refresh request |
| ras_n_o | output | 2**BANK_W | Decoded row strobes, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ADDR_W | Multiplexed address to the DRAM |
| wr_n_o | output | 1 | Buffered write enable |
| refresh_ok_o | output | 1 | One-cycle grant for a deferred refresh |

## Verification
The properties assume that mode_i only changes while the strobe is high. Any check that compares with a past cycle is limited to cycles whose previous edge was outside reset. The stimulus follows both rules. Each group of cycles opens with the strobe high for at least one cycle before a new mode takes effect, and external-mode groups keep the strobe high throughout. Inside an access, the bench changes row, column and bank inputs and refresh requests at random, so the capture and the deferral are tested against changing inputs.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SETUP,
    ST_ACTIVE
  } seq_state_t;

  localparam logic [2:0] MODE_EXT  = 3'b100;
  localparam logic [2:0] MODE_SLOW = 3'b101;
  localparam logic [2:0] MODE_FAST = 3'b110;

  function automatic logic mode_is_auto(input logic [2:0] m);
    return (m == MODE_SLOW) || (m == MODE_FAST);
  endfunction

endpackage

// File: rtl/dram_addr_path.sv
module dram_addr_path #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              sel_col_i,
  output logic [BANK_W-1:0] bank_eff_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              held_q;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] col_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              open_w;
  logic [ADDR_W-1:0] row_eff;
  logic [ADDR_W-1:0] col_eff;

  // latches pass inputs while strobe is high and on the first low edge
  assign open_w     = strobe_n_i | ~held_q;
  assign row_eff    = open_w ? row_i  : row_q;
  assign col_eff    = open_w ? col_i  : col_q;
  assign bank_eff_o = open_w ? bank_i : bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      held_q <= ~strobe_n_i;
      if (open_w) begin
        row_q  <= row_i;
        col_q  <= col_i;
        bank_q <= bank_i;
      end
      addr_q <= sel_col_i ? col_eff : row_eff;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dram_ras_decode.sv
module dram_ras_decode #(
  parameter int BANK_W    = 2,
  parameter int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ras_on_i,
  input  logic [BANK_W-1:0]    bank_i,
  output logic [NUM_BANKS-1:0] ras_n_o
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic ras_n_q;
    always_ff @(posedge clk) begin
      if (rst) ras_n_q <= 1'b1;
      else     ras_n_q <= ~(ras_on_i && (bank_i == BANK_W'(b)));
    end
    assign ras_n_o[b] = ras_n_q;
  end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
#(
  parameter int SLOW_HOLD = 2,
  parameter int FAST_HOLD = 1,
  parameter int COL_SETUP = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_i,
  input  logic       strobe_n_i,
  input  logic       ext_row_n_i,
  input  logic       ext_col_n_i,
  input  logic       ext_sel_col_i,
  output logic       ras_on_o,
  output logic       sel_col_o,
  output logic       cas_n_o
);

  localparam int HOLD_MAX = (SLOW_HOLD > FAST_HOLD) ? SLOW_HOLD : FAST_HOLD;
  localparam int WAIT_MAX = (HOLD_MAX > COL_SETUP) ? HOLD_MAX : COL_SETUP;
  localparam int CNT_W    = (WAIT_MAX <= 2) ? 1 : $clog2(WAIT_MAX);
  localparam logic [CNT_W-1:0] SLOW_LD  = CNT_W'(SLOW_HOLD - 1);
  localparam logic [CNT_W-1:0] FAST_LD  = CNT_W'(FAST_HOLD - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(COL_SETUP - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cas_n_q, cas_n_d;
  logic             ras_on_d, sel_col_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    ras_on_d  = 1'b0;
    sel_col_d = 1'b0;
    cas_n_d   = 1'b1;
    if (mode_i == MODE_EXT) begin
      state_d   = ST_IDLE;
      ras_on_d  = ~ext_row_n_i;
      cas_n_d   = ext_col_n_i;
      sel_col_d = ext_sel_col_i;
    end else if (mode_is_auto(mode_i) && !strobe_n_i) begin
      ras_on_d = 1'b1;
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_HOLD;
          cnt_d   = (mode_i == MODE_SLOW) ? SLOW_LD : FAST_LD;
        end
        ST_HOLD: begin
          if (cnt_q == '0) begin
            state_d   = ST_SETUP;
            cnt_d     = SETUP_LD;
            sel_col_d = 1'b1;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_SETUP: begin
          sel_col_d = 1'b1;
          if (cnt_q == '0) begin
            state_d = ST_ACTIVE;
            cas_n_d = 1'b0;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          sel_col_d = 1'b1;
          cas_n_d   = 1'b0;
        end
      endcase
    end else begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cas_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cas_n_q <= cas_n_d;
    end
  end

  assign ras_on_o  = ras_on_d;
  assign sel_col_o = sel_col_d;
  assign cas_n_o   = cas_n_q;

endmodule

// File: rtl/dram_refresh_defer.sv
module dram_refresh_defer (
  input  logic clk,
  input  logic rst,
  input  logic auto_i,
  input  logic strobe_n_i,
  input  logic req_i,
  output logic ok_o
);

  logic pend_q;
  logic ok_q;
  logic want;

  assign want = pend_q | req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      pend_q <= auto_i & ~strobe_n_i & want;
      ok_q   <= auto_i &  strobe_n_i & want;
    end
  end

  assign ok_o = ok_q;

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 2,
  parameter int SLOW_HOLD = 2,
  parameter int FAST_HOLD = 1,
  parameter int COL_SETUP = 1,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [2:0]           mode_i,
  input  logic                 strobe_n_i,
  input  logic [ADDR_W-1:0]    row_addr_i,
  input  logic [ADDR_W-1:0]    col_addr_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 ext_row_n_i,
  input  logic                 ext_col_n_i,
  input  logic                 ext_sel_col_i,
  input  logic                 wr_n_i,
  input  logic                 refresh_req_i,
  output logic [NUM_BANKS-1:0] ras_n_o,
  output logic                 cas_n_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 wr_n_o,
  output logic                 refresh_ok_o
);

  logic              ras_on;
  logic              sel_col;
  logic [BANK_W-1:0] bank_eff;

  dram_seq_fsm #(
    .SLOW_HOLD(SLOW_HOLD),
    .FAST_HOLD(FAST_HOLD),
    .COL_SETUP(COL_SETUP)
  ) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode_i),
    .strobe_n_i   (strobe_n_i),
    .ext_row_n_i  (ext_row_n_i),
    .ext_col_n_i  (ext_col_n_i),
    .ext_sel_col_i(ext_sel_col_i),
    .ras_on_o     (ras_on),
    .sel_col_o    (sel_col),
    .cas_n_o      (cas_n_o)
  );

  dram_addr_path #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .strobe_n_i(strobe_n_i),
    .row_i     (row_addr_i),
    .col_i     (col_addr_i),
    .bank_i    (bank_i),
    .sel_col_i (sel_col),
    .bank_eff_o(bank_eff),
    .addr_o    (addr_o)
  );

  dram_ras_decode #(
    .BANK_W   (BANK_W),
    .NUM_BANKS(NUM_BANKS)
  ) u_ras (
    .clk     (clk),
    .rst     (rst),
    .ras_on_i(ras_on),
    .bank_i  (bank_eff),
    .ras_n_o (ras_n_o)
  );

  dram_refresh_defer u_rfsh (
    .clk       (clk),
    .rst       (rst),
    .auto_i    (mode_is_auto(mode_i)),
    .strobe_n_i(strobe_n_i),
    .req_i     (refresh_req_i),
    .ok_o      (refresh_ok_o)
  );

  assign wr_n_o = wr_n_i;

endmodule

// File: rtl/dram_access_seq_chk.sv
module dram_access_seq_chk
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           mode_i,
  input logic                 strobe_n_i,
  input logic                 ext_col_n_i,
  input logic [NUM_BANKS-1:0] ras_n_o,
  input logic                 cas_n_o,
  input logic [ADDR_W-1:0]    addr_o,
  input logic                 refresh_ok_o
);

  logic auto_w;
  assign auto_w = mode_is_auto(mode_i);

  AST_RAS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    $countones(~ras_n_o) <= 1); // R4

  AST_RAS_STARTS: assert property (@(posedge clk) disable iff (rst)
    (auto_w && !strobe_n_i) |=> !(&ras_n_o)); // R3

  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (auto_w && strobe_n_i) |=> (&ras_n_o && cas_n_o)); // R7

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_is_auto($past(mode_i)) && !cas_n_o) |-> !(&ras_n_o)); // R6

  AST_COL_SETTLED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode_is_auto($past(mode_i)) && $fell(cas_n_o)) |-> $stable(addr_o)); // R6

  AST_GRANT_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && refresh_ok_o) |-> $past(strobe_n_i)); // R11

  AST_EXT_CAS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_i) == MODE_EXT) |-> (cas_n_o == $past(ext_col_n_i))); // R9

endmodule

bind dram_access_seq dram_access_seq_chk #(
  .ADDR_W(ADDR_W),
  .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/tb_dram_access_seq.sv
`timescale 1ns/1ps
module tb_dram_access_seq;
  localparam int AW = 8;
  localparam int BW = 2;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    mode = 3'b000;
  logic          strobe_n = 1'b1;
  logic [AW-1:0] row = '0, col = '0;
  logic [BW-1:0] bank = '0;
  logic          ext_row_n = 1'b1, ext_col_n = 1'b1, ext_sel = 1'b0;
  logic          wr_n = 1'b1, req = 1'b0;
  logic [NB-1:0] ras_n;
  logic          cas_n;
  logic [AW-1:0] addr;
  logic          wr_n_out, ok;

  always #2.5 clk = ~clk;

  dram_access_seq dut (
    .clk(clk), .rst(rst), .mode_i(mode), .strobe_n_i(strobe_n),
    .row_addr_i(row), .col_addr_i(col), .bank_i(bank),
    .ext_row_n_i(ext_row_n), .ext_col_n_i(ext_col_n), .ext_sel_col_i(ext_sel),
    .wr_n_i(wr_n), .refresh_req_i(req),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr), .wr_n_o(wr_n_out),
    .refresh_ok_o(ok)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // bench reference state
  bit            m_held = 1'b0, m_pend = 1'b0;
  int            m_j = 0;
  logic [AW-1:0] m_row = '0, m_col = '0;
  logic [BW-1:0] m_bank = '0;

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int hold_of(input logic [2:0] m);
    return (m == 3'b101) ? 2 : 1;
  endfunction

  // one clock with the inputs currently driven; compares at the following negedge
  task automatic cyc();
    bit            au, open;
    int            h;
    logic [AW-1:0] re, ce;
    logic [BW-1:0] be;
    logic [NB-1:0] e_ras;
    logic          e_cas, e_ok;
    logic [AW-1:0] e_addr;
    string         t_ras, t_addr, t_cas;
    #1;
    chk(wr_n_out == wr_n, "R10", "wr_n_o", 32'(wr_n_out), 32'(wr_n));
    au   = (mode == 3'b101) || (mode == 3'b110);
    h    = hold_of(mode);
    open = strobe_n || !m_held;
    re   = open ? row  : m_row;
    ce   = open ? col  : m_col;
    be   = open ? bank : m_bank;
    if (mode == 3'b100) begin
      m_j    = 0;
      e_ras  = ext_row_n ? '1 : ~(NB'(1) << be);
      e_cas  = ext_col_n;
      e_addr = ext_sel ? ce : re;
      t_ras = "R9"; t_addr = "R9"; t_cas = "R9";
    end else if (au && !strobe_n) begin
      m_j++;
      e_ras  = ~(NB'(1) << be);
      e_addr = (m_j >= h + 1) ? ce : re;
      e_cas  = !(m_j >= h + 2);
      t_ras  = (m_j == 1) ? "R3" : "R4";
      t_addr = (m_j <= h + 1) ? "R5" : "R8";
      t_cas  = "R6";
    end else begin
      m_j    = 0;
      e_ras  = '1;
      e_cas  = 1'b1;
      e_addr = re;
      t_ras  = au ? "R7" : "R12";
      t_addr = "R7";
      t_cas  = au ? "R7" : "R12";
    end
    e_ok   = au && strobe_n && (m_pend || req);
    m_pend = au && !strobe_n && (m_pend || req);
    m_held = !strobe_n;
    if (open) begin m_row = row; m_col = col; m_bank = bank; end
    @(posedge clk);
    @(negedge clk);
    chk(ras_n == e_ras,  t_ras,  "ras_n_o", 32'(ras_n), 32'(e_ras));
    chk(cas_n == e_cas,  t_cas,  "cas_n_o", 32'(cas_n), 32'(e_cas));
    chk(addr  == e_addr, t_addr, "addr_o",  32'(addr),  32'(e_addr));
    chk(ok    == e_ok,   "R11",  "refresh_ok_o", 32'(ok), 32'(e_ok));
  endtask

  task automatic rnd_addr();
    row  = AW'($urandom);
    col  = AW'($urandom);
    bank = BW'($urandom);
    wr_n = 1'($urandom);
  endtask

  // directed: measure row-fall to column-fall distance (R2)
  task automatic timing_probe(input logic [2:0] m, input int exp_gap);
    int gap;
    mode = m; strobe_n = 1'b1; rnd_addr(); cyc();
    strobe_n = 1'b0; cyc();
    gap = 0;
    for (int k = 1; k <= 6; k++) begin
      if (cas_n == 1'b0) break;
      gap++;
      rnd_addr();
      cyc();
    end
    chk(gap == exp_gap, "R2", "row-to-column strobe gap", 32'(gap), 32'(exp_gap));
    strobe_n = 1'b1; cyc();
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk(&ras_n && cas_n && !ok, "R1", "outputs in reset", {ras_n, cas_n, ok}, {4'hf, 1'b1, 1'b0});
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(&ras_n && cas_n && !ok, "R1", "outputs after reset", {ras_n, cas_n, ok}, {4'hf, 1'b1, 1'b0});

    timing_probe(3'b101, 3);
    timing_probe(3'b110, 2);

    // R8 directed: inputs changed during an access are ignored
    mode = 3'b101; strobe_n = 1'b1; row = 8'h3c; col = 8'hc3; bank = 2'd2; cyc();
    strobe_n = 1'b0; cyc();
    row = 8'h11; col = 8'h22; bank = 2'd1;
    for (int k = 0; k < 4; k++) cyc();
    chk(addr == 8'hc3, "R8", "held column", 32'(addr), 32'h0c3);
    chk(ras_n == 4'b1011, "R8", "held bank strobe", 32'(ras_n), 32'hb);
    strobe_n = 1'b1; cyc();

    // R11 directed: request during access deferred until strobe high
    mode = 3'b110; strobe_n = 1'b0; cyc();
    req = 1'b1; cyc(); req = 1'b0;
    chk(ok == 1'b0, "R11", "grant while strobe low", 32'(ok), 32'h0);
    cyc();
    strobe_n = 1'b1; cyc();
    chk(ok == 1'b1, "R11", "grant after release", 32'(ok), 32'h1);
    cyc();
    chk(ok == 1'b0, "R11", "grant is one cycle", 32'(ok), 32'h0);

    // R12 directed: unused mode ignores the strobe
    mode = 3'b000; strobe_n = 1'b1; cyc();
    strobe_n = 1'b0; cyc(); cyc();
    chk(&ras_n && cas_n, "R12", "idle in mode 000", {ras_n, cas_n}, 5'h1f);
    strobe_n = 1'b1; cyc();

    // random mix
    for (int g = 0; g < 300; g++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      strobe_n = 1'b1;
      req = 1'b0;
      if (pick < 4)      mode = 3'b101;
      else if (pick < 7) mode = 3'b110;
      else if (pick < 9) mode = 3'b100;
      else               mode = 3'($urandom_range(0, 3)) | ((pick & 1) != 0 ? 3'b000 : 3'b000);
      if (mode == 3'b011 && pick == 9 && ($urandom & 1) != 0) mode = 3'b111;
      rnd_addr();
      cyc();
      if (mode == 3'b100) begin
        for (int k = 0; k < 4; k++) begin
          rnd_addr();
          ext_row_n = 1'($urandom);
          ext_col_n = 1'($urandom);
          ext_sel   = 1'($urandom);
          req       = 1'($urandom);
          cyc();
        end
        ext_row_n = 1'b1; ext_col_n = 1'b1; ext_sel = 1'b0;
      end else begin
        int len;
        len = int'($urandom_range(1, 8));
        strobe_n = 1'b0;
        for (int k = 0; k < len; k++) begin
          req = ($urandom_range(0, 5) == 0);
          cyc();
          rnd_addr();
        end
        strobe_n = 1'b1;
        req = 1'b0;
        for (int k = 0; k < int'($urandom_range(1, 3)); k++) begin
          rnd_addr();
          cyc();
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule